// File: doc/BRIEF.md
# Event Timestamp Capture Unit

The unit runs a free 32-bit time counter that steps once per clock tick (8 ns at 125 MHz, a wrap roughly every 34.3 s). When the selected trigger fires, it latches the counter into a capture register. The trigger comes from one of two places: an asynchronous event pin, which is synchronised and edge-detected with a programmable polarity, or a single-cycle internal trigger pulse from elsewhere on the chip.

Software uses a small 16-bit register port. Through it, software programs the edge polarity, the overwrite policy and sequence counting, and it picks the trigger source. It polls a status word that holds a valid flag, an error flag and an 8-bit capture sequence count. The captured stamp and the live counter are each read as a low word followed by a high word. Reading the low word of the live counter freezes the high word, so the two halves always belong to the same instant.

A pending capture blocks later events unless overwrite is enabled. A blocked event raises the error flag. Writing the status word rearms the unit and restarts the sequence count.

Top module: `evt_stamp_unit`

## Requirements
- R1: The time counter increases by exactly one on every clock after reset and wraps from 0xFFFFFFFF to 0.
- R2: Register addresses are: 0 config, 1 status, 2 capture low, 3 capture high, 4 time low, 5 time high. A read strobe at address 4 copies the counter's upper 16 bits into a shadow, and address 5 returns that shadow.
- R3: Status bit 2 picks the trigger source: 1 means the internal trigger pulse, 0 means the external event pin. The source that is not selected causes no capture.
- R4: Config bit 0 picks the pin edge: 0 means rising, 1 means falling. The opposite edge causes no capture. For a pin change made while the counter holds T, the stamp is T+2, because of the two synchroniser stages.
- R5: An internal trigger pulse that is high in a cycle where the counter holds T stores T, and valid reads 1 from the next cycle onward.
- R6: Status bit 0 is valid and bit 1 is error. A status write with bit 0 = 0 clears both flags. A status write with bit 0 = 1 leaves them unchanged.
- R7: With overwrite off (config bit 1 = 0) and valid set, a further trigger leaves the stored stamp unchanged and sets error.
- R8: With overwrite on (config bit 1 = 1), every trigger replaces the stored stamp and error is not set.
- R9: Status bits 15:8 hold the sequence count. It increments on each accepted capture while config bit 2 is set, holds while config bit 2 is clear, saturates at 255, and returns to 0 on any status write.
- R10: After reset, config, status, the capture register and the shadow read 0, and the counter starts from the parameter TIME_RST_VAL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz time-base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_evt_i | input | 1 | Asynchronous external event pin |
| int_trig_i | input | 1 | Single-cycle internal trigger pulse |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (needed for the shadow snapshot) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational from address |

## Verification
Read data follows the address combinationally, so a register value is sampled in the same half cycle its address is driven. An internal trigger stores the counter value that is visible while the pulse is driven, and its effect on status is read from the next cycle on. A pin change shows up in the stamp as the counter value at the change plus two. The bench waits five cycles after each pin change before reading, and it drives and samples only on falling clock edges.

// File: rtl/esu_pkg.sv
package esu_pkg;
    localparam int TIME_W = 32;
    localparam int HALF_W = TIME_W / 2;
    localparam int SEQ_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CFG     = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT    = 3'd1;
    localparam logic [ADDR_W-1:0] A_CAP_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAP_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_TIME_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_TIME_HI = 3'd5;

    // config bits
    localparam int CB_FALL = 0;
    localparam int CB_OVW  = 1;
    localparam int CB_SEQ  = 2;
    // status bits
    localparam int SB_VALID = 0;
    localparam int SB_ERR   = 1;
    localparam int SB_SRC   = 2;

    typedef struct packed {
        logic              edge_fall;
        logic              ovw;
        logic              seq_en;
        logic              src_int;
        logic              valid;
        logic              err;
        logic [SEQ_W-1:0]  seq;
        logic [TIME_W-1:0] cap;
    } cap_state_t;
endpackage

// File: rtl/esu_edge_sync.sv
module esu_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], pin_i};
        edge_o  = fall_sel_i ? (~chain_q[STAGES-1] & chain_q[STAGES])
                             : (chain_q[STAGES-1] & ~chain_q[STAGES]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end
endmodule

// File: rtl/esu_time_base.sv
module esu_time_base #(
    parameter int                TIME_W  = 32,
    parameter logic [TIME_W-1:0] RST_VAL = '0,
    localparam int               HALF_W  = TIME_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap_i,
    output logic [TIME_W-1:0] time_o,
    output logic [HALF_W-1:0] shadow_o
);
    logic [TIME_W-1:0] time_d, time_q;
    logic [HALF_W-1:0] shadow_d, shadow_q;

    always_comb begin
        time_d   = time_q + TIME_W'(1);
        shadow_d = snap_i ? time_q[TIME_W-1:HALF_W] : shadow_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q   <= RST_VAL;
            shadow_q <= '0;
        end else begin
            time_q   <= time_d;
            shadow_q <= shadow_d;
        end
    end

    assign time_o   = time_q;
    assign shadow_o = shadow_q;
endmodule

// File: rtl/evt_stamp_unit.sv
module evt_stamp_unit
    import esu_pkg::*;
#(
    parameter logic [31:0] TIME_RST_VAL = 32'h0,
    parameter int          SYNC_STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_evt_i,
    input  logic        int_trig_i,
    input  logic [2:0]  reg_addr_i,
    input  logic        reg_wr_i,
    input  logic        reg_rd_i,
    input  logic [15:0] reg_wdata_i,
    output logic [15:0] reg_rdata_o
);
    cap_state_t        st_d, st_q;
    logic              ext_edge, trig, cfg_wr, stat_wr, snap;
    logic [TIME_W-1:0] time_now;
    logic [HALF_W-1:0] shadow_hi;

    // flattened views for the bound checker
    logic              valid_w, err_w, ovw_w, seq_en_w;
    logic [SEQ_W-1:0]  seq_w;
    logic [TIME_W-1:0] cap_w;

    esu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (ext_evt_i),
        .fall_sel_i(st_q.edge_fall),
        .edge_o    (ext_edge)
    );

    esu_time_base #(.TIME_W(TIME_W), .RST_VAL(TIME_RST_VAL)) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .snap_i  (snap),
        .time_o  (time_now),
        .shadow_o(shadow_hi)
    );

    always_comb begin
        cfg_wr  = reg_wr_i && (reg_addr_i == A_CFG);
        stat_wr = reg_wr_i && (reg_addr_i == A_STAT);
        snap    = reg_rd_i && (reg_addr_i == A_TIME_LO);
        trig    = st_q.src_int ? int_trig_i : ext_edge;

        st_d = st_q;
        if (cfg_wr) begin
            st_d.edge_fall = reg_wdata_i[CB_FALL];
            st_d.ovw       = reg_wdata_i[CB_OVW];
            st_d.seq_en    = reg_wdata_i[CB_SEQ];
        end
        if (stat_wr) begin
            st_d.src_int = reg_wdata_i[SB_SRC];
            st_d.seq     = '0;
            if (!reg_wdata_i[SB_VALID]) begin
                st_d.valid = 1'b0;
                st_d.err   = 1'b0;
            end
        end
        if (trig) begin
            if (!st_d.valid || st_q.ovw) begin
                st_d.cap   = time_now;
                st_d.valid = 1'b1;
                if (st_q.seq_en && (st_d.seq != {SEQ_W{1'b1}}))
                    st_d.seq = st_d.seq + SEQ_W'(1);
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr_i)
            A_CFG:     reg_rdata_o = {13'b0, st_q.seq_en, st_q.ovw, st_q.edge_fall};
            A_STAT:    reg_rdata_o = {st_q.seq, 5'b0, st_q.src_int, st_q.err, st_q.valid};
            A_CAP_LO:  reg_rdata_o = st_q.cap[HALF_W-1:0];
            A_CAP_HI:  reg_rdata_o = st_q.cap[TIME_W-1:HALF_W];
            A_TIME_LO: reg_rdata_o = time_now[HALF_W-1:0];
            A_TIME_HI: reg_rdata_o = shadow_hi;
            default:   reg_rdata_o = '0;
        endcase
    end

    assign valid_w  = st_q.valid;
    assign err_w    = st_q.err;
    assign ovw_w    = st_q.ovw;
    assign seq_en_w = st_q.seq_en;
    assign seq_w    = st_q.seq;
    assign cap_w    = st_q.cap;
endmodule

// File: rtl/esu_checker.sv
module esu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        trig,
    input logic        stat_wr,
    input logic        valid_w,
    input logic        err_w,
    input logic        ovw_w,
    input logic [7:0]  seq_w,
    input logic [31:0] cap_w,
    input logic [31:0] time_now
);
    assert_time_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> time_now == $past(time_now) + 32'd1);

    assert_valid_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> valid_w);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && valid_w && !ovw_w && !stat_wr) |=> ($stable(cap_w) && err_w));

    assert_seq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !trig) |=> seq_w == 8'd0);

    assert_seq_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_w == 8'hFF && !stat_wr) |=> seq_w == 8'hFF);
endmodule

bind evt_stamp_unit esu_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (trig),
    .stat_wr (stat_wr),
    .valid_w (valid_w),
    .err_w   (err_w),
    .ovw_w   (ovw_w),
    .seq_w   (seq_w),
    .cap_w   (cap_w),
    .time_now(time_now)
);

// File: tb/sim_evt_stamp_unit.sv
module sim_evt_stamp_unit;
    localparam int CLK_PERIOD = 8;
    localparam logic [31:0] START = 32'hFFFF_FFE0;

    logic        clk = 0, rst_n = 0, ext_evt = 0, int_trig = 0;
    logic [2:0]  reg_addr = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    evt_stamp_unit #(.TIME_RST_VAL(START)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_evt_i(ext_evt), .int_trig_i(int_trig),
        .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {ovw, clr_first, updated, err, seq[7:0]}
    localparam logic [11:0] VEC [6] = '{
        {1'b0, 1'b1, 1'b1, 1'b0, 8'd1},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'd1},
        {1'b0, 1'b1, 1'b1, 1'b0, 8'd1},
        {1'b1, 1'b0, 1'b1, 1'b0, 8'd2},
        {1'b1, 1'b0, 1'b1, 1'b0, 8'd3},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'd3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic fire_int(output logic [15:0] t);
        @(negedge clk);
        reg_addr = 3'd4; int_trig = 1;
        #1 t = reg_rdata;
        @(negedge clk);
        int_trig = 0;
    endtask

    task automatic set_pin(input logic v, output logic [15:0] t);
        @(negedge clk);
        reg_addr = 3'd4; ext_evt = v;
        #1 t = reg_rdata;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (CLK_PERIOD * 25000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, t, prev, l1;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R10 reset state
        rd(3'd0, v); chk("R10 config", v, 16'h0);
        rd(3'd1, v); chk("R10 status", v, 16'h0);
        rd(3'd2, v); chk("R10 capture", v, 16'h0);
        rd(3'd5, v); chk("R10 shadow", v, 16'h0);

        // R2 shadow coherence across the 32-bit wrap, R1 wrap
        rd(3'd4, v); chk("R10 counter near start", 32'(v >= 16'hFFE0), 1);
        repeat (40) @(negedge clk);
        rd(3'd5, v); chk("R2 shadow held", v, 16'hFFFF);
        rd(3'd4, v); chk("R1 wrapped low", 32'(v < 16'h0040), 1);
        rd(3'd5, v); chk("R2 shadow new", v, 16'h0000);

        // R1 step
        @(negedge clk); reg_addr = 3'd4; #1 l1 = reg_rdata;
        repeat (10) @(negedge clk); #1 v = reg_rdata;
        chk("R1 ten cycles", 32'(v - l1), 10);

        // table walk: internal trigger, R5 R6 R7 R8 R9
        wr(3'd1, 16'h0004);
        prev = 0;
        for (int i = 0; i < 6; i++) begin
            wr(3'd0, {13'b0, 1'b1, VEC[i][11], 1'b0});
            if (VEC[i][10]) wr(3'd1, 16'h0004);
            fire_int(t);
            rd(3'd2, v);
            chk($sformatf("R5/R7/R8 stamp vec %0d", i), v, VEC[i][9] ? t : prev);
            if (VEC[i][9]) prev = t;
            rd(3'd1, v);
            chk($sformatf("R6/R9 status vec %0d", i), v,
                {VEC[i][7:0], 5'b0, 1'b1, VEC[i][8], 1'b1});
        end

        // R3: external source selected, internal pulse ignored
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h0004);
        fire_int(t);
        rd(3'd1, v); chk("R3 internal ignored", v, 16'h0000);

        // R4 rising
        set_pin(1'b1, t);
        rd(3'd2, v); chk("R4 rising stamp", v, t + 16'd2);
        rd(3'd1, v); chk("R4 rising status", v, 16'h0101);
        wr(3'd1, 16'h0000);
        set_pin(1'b0, t);
        rd(3'd1, v); chk("R4 falling ignored in rising mode", v, 16'h0000);

        // R4 falling
        wr(3'd0, 16'h0005);
        set_pin(1'b1, t);
        rd(3'd1, v); chk("R4 rising ignored in falling mode", v, 16'h0000);
        set_pin(1'b0, t);
        rd(3'd2, v); chk("R4 falling stamp", v, t + 16'd2);
        rd(3'd1, v); chk("R4 falling status", v, 16'h0101);

        // R9 saturation with overwrite
        wr(3'd1, 16'h0004);
        wr(3'd0, 16'h0006);
        @(negedge clk); int_trig = 1;
        repeat (300) @(negedge clk);
        int_trig = 0;
        rd(3'd1, v); chk("R9 saturate", v, 16'hFF05);

        // R6 write-1 keeps valid, R9 write resets count, count disabled
        wr(3'd0, 16'h0002);
        wr(3'd1, 16'h0005);
        rd(3'd1, v); chk("R6 write one keeps valid, R9 reset", v, 16'h0005);
        fire_int(t);
        rd(3'd2, v); chk("R8 overwrite stamp", v, t);
        rd(3'd1, v); chk("R9 count held when disabled", v, 16'h0005);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule